// File: doc/BRIEF.md
# Collision Backoff Delay Generator

After a collision, a half-duplex CSMA/CD transmitter must wait a random number of slot times before it tries again. This block turns a collision report into that wait. The report is a one-cycle request that carries the number of collisions the current frame has already had. The block draws a random slot count from a free-running LFSR and scales it by the slot time. It presents the delay for one cycle, then counts it down and pulses `ready` when the wait is over. When the frame has used up its retry budget, the block raises a give-up pulse instead of starting a wait.

The block also reports whether the medium may be used. With full duplex selected there are no collisions at all, so collision requests are ignored and the medium is always reported clear. In half duplex, the medium is clear only while the bus-throttle window is open. Every collision the block accepts is counted in a wrapping event counter.

Top module: `collision_backoff`

## Requirements
- R1: After reset, `delay_valid`, `ready`, `give_up` and `collision_cnt` are all zero, and the block is idle, so the first request is accepted.
- R2: For an accepted request with `retry_cnt` below 16, the exponent is `retry_cnt`+1, capped at 10. The slot count is the low 10 bits of the LFSR ANDed with 2^exponent-1. The LFSR is 16 bits wide and resets to 16'hACE1. On every clock out of reset it shifts left by one, and its new bit 0 is bit15 ^ bit13 ^ bit12 ^ bit10. The value used is the one held before the accepting edge.
- R3: `delay` equals the slot count times 51. It is shown together with a one-cycle `delay_valid` pulse in the cycle after the accepting edge.
- R4: A request with `retry_cnt` of 16 or more produces a one-cycle `give_up` pulse in the cycle after the accepting edge. No delay is produced and no countdown is started.
- R5: `ready` pulses for exactly one cycle, delay+1 cycles after the `delay_valid` cycle. A delay of 0 gives `ready` in the very next cycle.
- R6: While `full_duplex` is 1, `medium_clear` is 1 and requests are ignored: no delay, no give-up and no count change.
- R7: While `full_duplex` is 0, `medium_clear` equals `throttle_open`.
- R8: `collision_cnt` increases by one in the cycle after each accepted request, including a request that ends in give-up.
- R9: A request that arrives while a countdown is running is ignored. It produces no new delay and leaves `collision_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle collision report |
| retry_cnt | input | 5 | Collisions already seen for this frame |
| full_duplex | input | 1 | Full-duplex operation selected |
| throttle_open | input | 1 | Bus-throttle window is open |
| delay | output | 16 | Backoff delay in bit times |
| delay_valid | output | 1 | One-cycle strobe for `delay` |
| ready | output | 1 | One-cycle pulse when the backoff has elapsed |
| give_up | output | 1 | One-cycle pulse when the retry budget is spent |
| medium_clear | output | 1 | Medium may be used |
| collision_cnt | output | 16 | Accepted collision events, wraps |

## Verification
The bench tests the exponent boundaries: retry 0 gives a one-bit slot mask, and retry 12 must still use only 10 bits. A design that misses the cap would produce delays above 1023 slots, and one with an off-by-one would halve or double the range. It also tests retry counts 16 and 20. A design with the wrong give-up threshold would start a countdown there, or would give up at 15. A request arriving mid-countdown and a request in full duplex must leave no trace. A design that accepted either would show an extra delay strobe or a counter step. Zero-slot draws check that `ready` follows one cycle after the strobe, which exposes an off-by-one in the countdown.

// File: rtl/collision_backoff.sv
module collision_backoff #(
  parameter int EXP_CAP   = 10,
  parameter int SLOT_TIME = 51,
  parameter int MAX_TRIES = 16,
  parameter int RW        = 5,
  parameter int CW        = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int DW = $clog2(((1 << EXP_CAP) - 1) * SLOT_TIME + 1),
  localparam int EW = $clog2(EXP_CAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [RW-1:0] retry_cnt,
  input  logic          full_duplex,
  input  logic          throttle_open,
  output logic [DW-1:0] delay,
  output logic          delay_valid,
  output logic          ready,
  output logic          give_up,
  output logic          medium_clear,
  output logic [CW-1:0] collision_cnt
);

  logic [15:0]      lfsr;
  logic [DW-1:0]    cnt;
  logic             busy;
  logic [EW-1:0]    expo;
  logic [EXP_CAP:0] mask_w;
  logic [EXP_CAP-1:0] slots;
  logic [DW-1:0]    new_delay;
  logic             accept;

  assign medium_clear = full_duplex | throttle_open;
  assign accept       = req & ~full_duplex & ~busy;

  assign expo   = (retry_cnt >= RW'(EXP_CAP)) ? EW'(EXP_CAP) : EW'(retry_cnt + RW'(1));
  assign mask_w = ((EXP_CAP+1)'(1) << expo) - (EXP_CAP+1)'(1);
  assign slots  = lfsr[EXP_CAP-1:0] & mask_w[EXP_CAP-1:0];
  assign new_delay = DW'(slots) * DW'(SLOT_TIME);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr          <= LFSR_SEED;
      cnt           <= '0;
      busy          <= 1'b0;
      delay         <= '0;
      delay_valid   <= 1'b0;
      ready         <= 1'b0;
      give_up       <= 1'b0;
      collision_cnt <= '0;
    end else begin
      lfsr        <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      delay_valid <= 1'b0;
      ready       <= 1'b0;
      give_up     <= 1'b0;
      if (accept) begin
        collision_cnt <= collision_cnt + CW'(1);
        if (retry_cnt >= RW'(MAX_TRIES)) begin
          give_up <= 1'b1;
        end else begin
          delay       <= new_delay;
          delay_valid <= 1'b1;
          cnt         <= new_delay;
          busy        <= 1'b1;
        end
      end else if (busy) begin
        if (cnt == '0) begin
          ready <= 1'b1;
          busy  <= 1'b0;
        end else begin
          cnt <= cnt - DW'(1);
        end
      end
    end
  end

  AST_DELAY_WHOLE_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    delay_valid |-> (delay % DW'(SLOT_TIME)) == '0); // R3
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready); // R5
  AST_GIVEUP_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    give_up |-> (!delay_valid && !busy)); // R4
  AST_FULL_DUPLEX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req && full_duplex) |=> (!delay_valid && !give_up && $stable(collision_cnt))); // R6
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req && busy) |=> (!delay_valid && $stable(collision_cnt))); // R9
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !full_duplex && !busy) |=> collision_cnt == $past(collision_cnt) + CW'(1)); // R8

endmodule

// File: tb/collision_backoff_test.sv
module collision_backoff_test;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, full_duplex = 1'b0, throttle_open = 1'b0;
  logic [4:0] retry_cnt = '0;
  logic [15:0] delay, collision_cnt;
  logic delay_valid, ready, give_up, medium_clear;

  collision_backoff uut (
    .clk(clk), .rst_n(rst_n), .req(req), .retry_cnt(retry_cnt),
    .full_duplex(full_duplex), .throttle_open(throttle_open),
    .delay(delay), .delay_valid(delay_valid), .ready(ready), .give_up(give_up),
    .medium_clear(medium_clear), .collision_cnt(collision_cnt));

  always #2 clk = ~clk;

  typedef struct { int kind; int value; int at; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0, cyc = 0, exp_cnt = 0;
  logic [15:0] lm;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    lm <= !rst_n ? 16'hACE1 : {lm[14:0], lm[15] ^ lm[13] ^ lm[12] ^ lm[10]};
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic take(input int kind, input int value);
    item_t it;
    if (q.size() == 0) begin
      check(0, "R9/R6 unexpected event", kind, -1);
    end else begin
      it = q.pop_front();
      check(it.kind == kind, {it.tag, " kind"}, kind, it.kind);
      check(it.value == value, {it.tag, " value"}, value, it.value);
      check(it.at == cyc, {it.tag, " cycle"}, cyc, it.at);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (delay_valid) take(0, int'(delay));
    if (give_up) take(1, 0);
    if (ready) take(2, 0);
  end

  task automatic collide(input int r, input bit poke);
    int e, d;
    item_t it;
    @(negedge clk);
    e = (r + 1 > 10) ? 10 : r + 1;
    d = (int'(lm[9:0]) & ((1 << e) - 1)) * 51;
    if (r >= 16) begin
      it = '{1, 0, cyc + 1, "R4"}; q.push_back(it);
    end else begin
      it = '{0, d, cyc + 1, "R2/R3"}; q.push_back(it);
      it = '{2, 0, cyc + d + 2, "R5"}; q.push_back(it);
    end
    exp_cnt++;
    retry_cnt = 5'(r); req = 1'b1;
    @(negedge clk); req = 1'b0;
    if (poke && r < 16 && d > 0) begin
      retry_cnt = 5'd3; req = 1'b1;  // R9: must be ignored
      @(negedge clk); req = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(int'(collision_cnt) == exp_cnt, "R8 count", int'(collision_cnt), exp_cnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!delay_valid && !ready && !give_up, "R1 strobes", int'(delay_valid), 0);
    check(collision_cnt == 0, "R1 count", int'(collision_cnt), 0);
    check(medium_clear == 1'b0, "R7 closed", int'(medium_clear), 0);
    throttle_open = 1'b1; #1;
    check(medium_clear == 1'b1, "R7 open", int'(medium_clear), 1);
    throttle_open = 1'b0;
    full_duplex = 1'b1; #1;
    check(medium_clear == 1'b1, "R6 clear", int'(medium_clear), 1);
    @(negedge clk); retry_cnt = 5'd2; req = 1'b1;
    @(negedge clk); req = 1'b0;
    repeat (4) @(negedge clk);
    check(collision_cnt == 0, "R6 ignored", int'(collision_cnt), 0);
    full_duplex = 1'b0;
    collide(0, 0); collide(0, 0); collide(1, 0); collide(2, 0);
    collide(3, 0); collide(5, 0); collide(0, 0); collide(1, 0);
    for (int i = 0; i < 3; i++) collide(6, 1);
    collide(16, 0); collide(20, 0);
    collide(12, 0);
    collide(31, 0);
    check(q.size() == 0, "R5 drained", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule